// File: doc/BRIEF.md
# Slow-Rate Infrared Pulse Transmitter

This block turns a stream of bytes into the pulse train that drives an infrared LED at the slow serial rates, from 2400 to 115200 baud. Each byte is sent with asynchronous framing: one start bit, eight data bits least significant first, and one stop bit. A bit cell that carries a zero opens with one short light pulse. A bit cell that carries a one stays dark. The output level can be inverted to suit the transceiver.

Software writes a 16-bit configuration word into a shadow register while the PHY enable is low. The word holds a 6-bit rate divisor (`div`) in bits 15:10, a 5-bit pulse-width code (`wid`) in bits 9:5 and a 5-bit preamble field in bits 4:0. The preamble field is stored and read back but has no effect at these rates. On the rising edge of the enable, the shadow word, the primary-clock select and a mode-conflict flag are all applied. The applied word can be read back on `cfg_applied`.

The bit rate is 115200/(div+1). It comes from a fractional phase accumulator that runs on the primary clock, which is 40 MHz or 48 MHz. The pulse length is (wid+1)×(div+1) ticks of a base clock: 8 MHz from a 40 MHz primary clock, or 16 MHz from a 48 MHz primary clock. This lets software shorten pulses at low rates to save power. Data enters through a valid/ready handshake.

The transmit state machine has four states:
- IDLE waits for a byte. The transition *accept* (valid and ready both high) goes to START.
- START goes to DATA on *cell end*.
- DATA repeats on *cell end* for data bits 0 to 6. The transition *last data* (cell end on bit 7) goes to STOP.
- STOP goes back to IDLE on *cell end*.
- From any state, *abort* (enable low) returns to IDLE.

Top module: `sir_pulse_tx`

## Requirements
- R1: After reset the following hold:
  - `ir_tx` equals the `tx_pol` level.
  - `busy`, `byte_ready` and `cfg_err` are 0.
  - `cfg_applied` is 0.
- R2: `cfg_we` loads `cfg_wdata` into the shadow word only while `phy_en` is 0. Loading is ignored while `phy_en` is 1. On the cycle after `phy_en` rises, `cfg_applied` holds the shadow word (div in [15:10], wid in [9:5], preamble in [4:0]). It does not change at any other time.
- R3: `cfg_err` is updated only at the rising edge of `phy_en`. It becomes 1 when two or more bits of `mode_bits` are set at that edge, and 0 otherwise.
- R4: `byte_ready` is 1 only in IDLE, with `phy_en` high and already high on the previous cycle. It is 0 in the cycle right after `phy_en` rises.
- R5: A byte is sent as a start cell (0), then data bits 0 to 7, then a stop cell (1). A zero cell begins with a pulse. A one cell has no pulse.
- R6: Each bit cell lasts UNITS×(div+1)/RATE_STEP primary-clock cycles on average, where UNITS is the parameter for the selected primary clock. The cells start at the accept edge.
- R7: Each pulse starts at the start of its cell and lasts (wid+1)×(div+1)×D cycles. D is 5 when `clk48_sel` was 0 at the enable edge, and 3 when it was 1.
- R8: `busy` rises at the accept edge and falls exactly when the stop cell ends. `byte_ready` returns in that same cycle.
- R9: When `tx_pol` is 1, `ir_tx` is the complement of the pulse level, including while idle.
- R10: `phy_en` at 0 ends any frame at the next edge: `busy` goes to 0 and the pulse goes off.
- R11: A `cfg_we` in the same cycle as the rising edge of `phy_en` is ignored, because `phy_en` is already 1. The earlier shadow word is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Primary clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phy_en | input | 1 | PHY enable; its rising edge applies the configuration |
| cfg_we | input | 1 | Write strobe for the shadow configuration word |
| cfg_wdata | input | 16 | Configuration word: div[15:10], wid[9:5], preamble[4:0] |
| mode_bits | input | 3 | Mode selection bits, checked for conflict at the enable edge |
| clk48_sel | input | 1 | 1 selects a 48 MHz primary clock, 0 selects 40 MHz; latched at the enable edge |
| tx_pol | input | 1 | Output polarity inversion |
| byte_valid | input | 1 | Byte offered for transmission |
| byte_data | input | 8 | Byte to send |
| byte_ready | output | 1 | Block can take a byte this cycle |
| busy | output | 1 | Frame in progress |
| ir_tx | output | 1 | Pulse output to the LED driver |
| cfg_applied | output | 16 | Applied configuration word |
| cfg_err | output | 1 | Mode conflict seen at the last enable edge |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a shadow write and the enable's rising edge. The bench raises `phy_en` and pulses `cfg_we` with a new word on the same clock. It then expects `cfg_applied` to show the word written earlier, not the new one.

The second pair is the end of a stop cell and the return of the handshake. The bench requires `busy` to drop and `byte_ready` to rise on the same edge, exactly ten cell lengths after acceptance. The cell lengths are computed from the divisor and clock select.

Each waveform is compared cycle by cycle against the pulse position and length worked out arithmetically from div and wid. The sweep covers both clock selects and several divisor and width values.

// File: rtl/sir_tx_pkg.sv
package sir_tx_pkg;

    localparam int CFG_W = 16;
    localparam int DIV_W = 6;
    localparam int WID_W = 5;
    localparam int PRE_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } tx_state_t;

    function automatic logic [DIV_W-1:0] cfg_div(input logic [CFG_W-1:0] word);
        return word[CFG_W-1 -: DIV_W];
    endfunction

    function automatic logic [WID_W-1:0] cfg_wid(input logic [CFG_W-1:0] word);
        return word[PRE_W +: WID_W];
    endfunction

endpackage

// File: rtl/sir_cfg_latch.sv
module sir_cfg_latch
    import sir_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phy_en,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [2:0]       mode_bits,
    input  logic             clk48_sel,
    output logic [CFG_W-1:0] applied,
    output logic             cfg_err,
    output logic             sel48_q,
    output logic             en_q
);

    logic [CFG_W-1:0] shadow;
    logic             en_rise;
    logic             mode_clash;

    assign en_rise    = phy_en && !en_q;
    assign mode_clash = (mode_bits[0] & mode_bits[1]) |
                        (mode_bits[0] & mode_bits[2]) |
                        (mode_bits[1] & mode_bits[2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (cfg_we && !phy_en) begin
            shadow <= cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            applied <= '0;
            cfg_err <= 1'b0;
            sel48_q <= 1'b0;
        end else begin
            en_q <= phy_en;
            if (en_rise) begin
                applied <= shadow;
                cfg_err <= mode_clash;
                sel48_q <= clk48_sel;
            end
        end
    end

    // R2: applied word holds whenever the enable was already high
    a_r2_applied_hold: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> $stable(applied));

    // R3: error flag moves only on an enable rising edge
    a_r3_err_only_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !(phy_en && !en_q) |=> $stable(cfg_err));

    // R3: a conflict at the edge is reported
    a_r3_err_on_clash: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_en && !en_q && ($countones(mode_bits) > 1)) |=> cfg_err);

endmodule

// File: rtl/sir_bit_clock.sv
module sir_bit_clock
    import sir_tx_pkg::*;
#(
    parameter int RATE_STEP   = 1152,
    parameter int CLK_A_UNITS = 400000,
    parameter int CLK_B_UNITS = 480000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sel48,
    input  logic [DIV_W-1:0] divisor,
    output logic             cell_end
);

    localparam int MAX_UNITS = (CLK_A_UNITS > CLK_B_UNITS) ? CLK_A_UNITS : CLK_B_UNITS;
    localparam int ACC_W     = $clog2(MAX_UNITS * (1 << DIV_W) + RATE_STEP) + 1;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] unit_sel;
    logic [ACC_W-1:0] thr;
    logic [ACC_W-1:0] sum;

    assign unit_sel = sel48 ? ACC_W'(CLK_B_UNITS) : ACC_W'(CLK_A_UNITS);
    assign thr      = unit_sel * (ACC_W'(divisor) + ACC_W'(1));
    assign sum      = acc + ACC_W'(RATE_STEP);
    assign cell_end = run && (sum >= thr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (!run) begin
            acc <= '0;
        end else if (cell_end) begin
            acc <= sum - thr;
        end else begin
            acc <= sum;
        end
    end

    // R6: phase residue stays below one cell while a frame runs
    a_r6_acc_below_cell: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (acc < thr));

endmodule

// File: rtl/sir_pulse_shaper.sv
module sir_pulse_shaper
    import sir_tx_pkg::*;
#(
    parameter int TICK_DIV_A = 5,
    parameter int TICK_DIV_B = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_start,
    input  logic             zero_bit,
    input  logic             stop_all,
    input  logic             sel48,
    input  logic [DIV_W-1:0] divisor,
    input  logic [WID_W-1:0] width,
    output logic             pulse_on
);

    localparam int MAX_DIV = (TICK_DIV_A > TICK_DIV_B) ? TICK_DIV_A : TICK_DIV_B;
    localparam int PS_W    = $clog2(MAX_DIV) + 1;
    localparam int TGT_W   = DIV_W + WID_W + 1;

    logic [PS_W-1:0]  presc;
    logic [PS_W-1:0]  presc_lim;
    logic [TGT_W-1:0] ticks;
    logic [TGT_W-1:0] target;

    assign presc_lim = sel48 ? PS_W'(TICK_DIV_B - 1) : PS_W'(TICK_DIV_A - 1);
    assign target    = (TGT_W'(width) + TGT_W'(1)) * (TGT_W'(divisor) + TGT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_on <= 1'b0;
            presc    <= '0;
            ticks    <= '0;
        end else if (stop_all) begin
            pulse_on <= 1'b0;
            presc    <= '0;
            ticks    <= '0;
        end else if (cell_start) begin
            pulse_on <= zero_bit;
            presc    <= '0;
            ticks    <= '0;
        end else if (pulse_on) begin
            if (presc == presc_lim) begin
                presc <= '0;
                ticks <= ticks + TGT_W'(1);
                if (ticks + TGT_W'(1) == target) begin
                    pulse_on <= 1'b0;
                end
            end else begin
                presc <= presc + PS_W'(1);
            end
        end
    end

    // R7: a running pulse never counts past its programmed length
    a_r7_ticks_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_on |-> (ticks < target));

    // R10: enable loss extinguishes the pulse at the next edge
    a_r10_pulse_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_all |=> !pulse_on);

endmodule

// File: rtl/sir_pulse_tx.sv
module sir_pulse_tx
    import sir_tx_pkg::*;
#(
    parameter int RATE_STEP   = 1152,
    parameter int CLK_A_UNITS = 400000,
    parameter int CLK_B_UNITS = 480000,
    parameter int TICK_DIV_A  = 5,
    parameter int TICK_DIV_B  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        phy_en,
    input  logic        cfg_we,
    input  logic [15:0] cfg_wdata,
    input  logic [2:0]  mode_bits,
    input  logic        clk48_sel,
    input  logic        tx_pol,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    output logic        byte_ready,
    output logic        busy,
    output logic        ir_tx,
    output logic [15:0] cfg_applied,
    output logic        cfg_err
);

    localparam int NBITS = 8;
    localparam int IDX_W = $clog2(NBITS);

    tx_state_t        state, state_nx;
    logic [NBITS-1:0] shreg;
    logic [IDX_W-1:0] bit_idx;
    logic             en_q;
    logic             sel48_q;
    logic             cell_end;
    logic             cell_start;
    logic             zero_bit;
    logic             pulse_on;
    logic             accept;

    sir_cfg_latch u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .phy_en    (phy_en),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .mode_bits (mode_bits),
        .clk48_sel (clk48_sel),
        .applied   (cfg_applied),
        .cfg_err   (cfg_err),
        .sel48_q   (sel48_q),
        .en_q      (en_q)
    );

    sir_bit_clock #(
        .RATE_STEP   (RATE_STEP),
        .CLK_A_UNITS (CLK_A_UNITS),
        .CLK_B_UNITS (CLK_B_UNITS)
    ) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .sel48    (sel48_q),
        .divisor  (cfg_div(cfg_applied)),
        .cell_end (cell_end)
    );

    sir_pulse_shaper #(
        .TICK_DIV_A (TICK_DIV_A),
        .TICK_DIV_B (TICK_DIV_B)
    ) u_shape (
        .clk        (clk),
        .rst_n      (rst_n),
        .cell_start (cell_start),
        .zero_bit   (zero_bit),
        .stop_all   (!phy_en),
        .sel48      (sel48_q),
        .divisor    (cfg_div(cfg_applied)),
        .width      (cfg_wid(cfg_applied)),
        .pulse_on   (pulse_on)
    );

    assign busy       = (state != ST_IDLE);
    assign byte_ready = (state == ST_IDLE) && en_q && phy_en;
    assign accept     = byte_valid && byte_ready;
    assign ir_tx      = pulse_on ^ tx_pol;

    // next-state logic
    always_comb begin
        state_nx = state;
        if (!phy_en) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (accept)   state_nx = ST_START;
                ST_START: if (cell_end) state_nx = ST_DATA;
                ST_DATA:  if (cell_end && bit_idx == IDX_W'(NBITS - 1)) state_nx = ST_STOP;
                ST_STOP:  if (cell_end) state_nx = ST_IDLE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // cell-start outputs toward the pulse shaper
    always_comb begin
        cell_start = 1'b0;
        zero_bit   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    cell_start = 1'b1;
                    zero_bit   = 1'b1;
                end
            end
            ST_START: begin
                if (cell_end) begin
                    cell_start = 1'b1;
                    zero_bit   = !shreg[0];
                end
            end
            ST_DATA: begin
                if (cell_end) begin
                    cell_start = 1'b1;
                    zero_bit   = (bit_idx == IDX_W'(NBITS - 1)) ? 1'b0 : !shreg[1];
                end
            end
            ST_STOP: begin
                if (cell_end) begin
                    cell_start = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // shift register and bit index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_idx <= '0;
        end else if (accept) begin
            shreg   <= byte_data;
            bit_idx <= '0;
        end else if (state == ST_DATA && cell_end) begin
            shreg   <= {1'b0, shreg[NBITS-1:1]};
            bit_idx <= bit_idx + IDX_W'(1);
        end
    end

    // R8: an accepted byte makes the block busy
    a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    // R10: enable loss ends the frame
    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_en |=> !busy);

    // R5: no light outside a frame
    a_r5_dark_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pulse_on);

    // R4: ready never shows in the first cycle of the enable
    a_r4_ready_after_apply: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |-> (en_q && phy_en));

endmodule

// File: tb/sir_pulse_tx_test.sv
`timescale 1ns/1ps
module sir_pulse_tx_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        phy_en;
    logic        cfg_we;
    logic [15:0] cfg_wdata;
    logic [2:0]  mode_bits;
    logic        clk48_sel;
    logic        tx_pol;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        byte_ready;
    logic        busy;
    logic        ir_tx;
    logic [15:0] cfg_applied;
    logic        cfg_err;

    int tests = 0;
    int fails = 0;
    int cur_b = 0;
    int cur_w = 0;
    int cur_s = 0;
    int cur_word = 0;

    always #2 clk = ~clk;

    sir_pulse_tx #(
        .RATE_STEP   (1),
        .CLK_A_UNITS (40),
        .CLK_B_UNITS (48),
        .TICK_DIV_A  (5),
        .TICK_DIV_B  (3)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .phy_en      (phy_en),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .mode_bits   (mode_bits),
        .clk48_sel   (clk48_sel),
        .tx_pol      (tx_pol),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .byte_ready  (byte_ready),
        .busy        (busy),
        .ir_tx       (ir_tx),
        .cfg_applied (cfg_applied),
        .cfg_err     (cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // program and apply a configuration; ends at a negedge with the word applied
    task automatic prog(input int b, input int w, input int p, input bit s48, input logic [2:0] modes);
        @(negedge clk);
        phy_en = 1'b0;
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = {6'(b), 5'(w), 5'(p)};
        clk48_sel = s48;
        mode_bits = modes;
        @(negedge clk);
        cfg_we = 1'b0;
        phy_en = 1'b1;
        @(negedge clk);
        cur_b = b; cur_w = w; cur_s = int'(s48);
        cur_word = int'({6'(b), 5'(w), 5'(p)});
        check(cfg_applied == 16'(cur_word), "R2 applied readback", int'(cfg_applied), cur_word);
    endtask

    // send one byte and compare the whole frame cycle by cycle
    task automatic send(input logic [7:0] d, input string tag);
        int thr, plen, bad, bad_j, bitv, k;
        logic e;
        thr  = (cur_s != 0 ? 48 : 40) * (cur_b + 1);
        plen = (cur_w + 1) * (cur_b + 1) * (cur_s != 0 ? 3 : 5);
        bad = 0; bad_j = -1;
        byte_valid = 1'b1;
        byte_data  = d;
        while (!byte_ready) @(negedge clk);
        @(negedge clk);
        byte_valid = 1'b0;
        for (int j = 0; j < 10 * thr; j++) begin
            k = j / thr;
            bitv = (k == 0) ? 0 : (k == 9) ? 1 : int'(d[k-1]);
            e = ((bitv == 0) && ((j % thr) < plen)) ^ tx_pol;
            if (ir_tx !== e || busy !== 1'b1) begin
                if (bad == 0) bad_j = j;
                bad++;
            end
            @(negedge clk);
        end
        check(bad == 0, {tag, " frame waveform, actual=first bad cycle"}, bad_j, -1);
        check(busy == 1'b0 && byte_ready == 1'b1, "R8 busy drop with ready return",
              int'({busy, byte_ready}), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int wl [3];
        rst_n = 1'b0; phy_en = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
        mode_bits = 3'b000; clk48_sel = 1'b0; tx_pol = 1'b0;
        byte_valid = 1'b0; byte_data = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ir_tx == 1'b0, "R1 ir_tx idle", int'(ir_tx), 0);
        check(busy == 1'b0 && byte_ready == 1'b0, "R1 busy/ready", int'({busy, byte_ready}), 0);
        check(cfg_applied == 16'h0 && cfg_err == 1'b0, "R1 config outputs", int'(cfg_applied), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(byte_ready == 1'b0, "R4 ready low while disabled", int'(byte_ready), 0);

        // R4 ready appears one cycle after the enable edge
        phy_en = 1'b1;
        #1;
        check(byte_ready == 1'b0, "R4 ready low in rise cycle", int'(byte_ready), 0);
        @(negedge clk);
        check(byte_ready == 1'b1, "R4 ready after apply", int'(byte_ready), 1);

        // R2 / R3 basic programming
        prog(0, 2, 7, 1'b0, 3'b001);
        check(cfg_err == 1'b0, "R3 single mode no error", int'(cfg_err), 0);

        // R2 write while enabled is ignored
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 16'hFFFF;
        @(negedge clk);
        cfg_we = 1'b0; phy_en = 1'b0;
        @(negedge clk);
        phy_en = 1'b1;
        @(negedge clk);
        check(cfg_applied == 16'(cur_word), "R2 write while enabled ignored", int'(cfg_applied), cur_word);

        // R11 write in the same cycle as the enable edge
        phy_en = 1'b0;
        @(negedge clk);
        phy_en = 1'b1; cfg_we = 1'b1; cfg_wdata = 16'h1234;
        @(negedge clk);
        cfg_we = 1'b0;
        check(cfg_applied == 16'(cur_word), "R11 write at enable edge ignored", int'(cfg_applied), cur_word);

        // R3 conflict flag set then cleared
        prog(1, 3, 5, 1'b0, 3'b011);
        check(cfg_err == 1'b1, "R3 two modes flag error", int'(cfg_err), 1);
        prog(1, 3, 5, 1'b0, 3'b111);
        check(cfg_err == 1'b1, "R3 three modes flag error", int'(cfg_err), 1);
        prog(1, 3, 5, 1'b0, 3'b100);
        check(cfg_err == 1'b0, "R3 error cleared", int'(cfg_err), 0);

        // R5 data patterns at the fastest rate
        prog(0, 2, 0, 1'b0, 3'b001);
        send(8'h00, "R5 all zeros");
        send(8'hFF, "R5 all ones");
        send(8'h01, "R5 lsb first");
        send(8'h80, "R5 msb last");
        send(8'h55, "R5 alternating");
        send(8'h3C, "R5 mixed");

        // R6 R7 sweep of rate divisor, width and clock select
        for (int s = 0; s < 2; s++) begin
            if (s == 0) begin wl[0] = 0; wl[1] = 3; wl[2] = 6; end
            else        begin wl[0] = 0; wl[1] = 7; wl[2] = 14; end
            for (int b = 0; b < 4; b++) begin
                for (int wi = 0; wi < 3; wi++) begin
                    prog(b, wl[wi], 0, s[0], 3'b001);
                    send(8'hA5 ^ 8'(b * 16 + wi), "R6 R7 sweep");
                end
            end
        end

        // R9 inverted polarity
        prog(1, 4, 0, 1'b0, 3'b001);
        tx_pol = 1'b1;
        @(negedge clk);
        check(ir_tx == 1'b1, "R9 inverted idle level", int'(ir_tx), 1);
        send(8'h96, "R9 inverted frame");
        tx_pol = 1'b0;

        // R10 abort mid frame
        prog(1, 2, 0, 1'b0, 3'b001);
        byte_valid = 1'b1; byte_data = 8'h00;
        while (!byte_ready) @(negedge clk);
        @(negedge clk);
        byte_valid = 1'b0;
        repeat (85) @(negedge clk);
        phy_en = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R10 abort clears busy", int'(busy), 0);
        check(ir_tx == 1'b0, "R10 abort darkens output", int'(ir_tx), 0);
        check(byte_ready == 1'b0, "R10 no ready while disabled", int'(byte_ready), 0);
        phy_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        send(8'h5A, "R10 recovery after abort");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule